// File: doc/BRIEF.md
# Processor Reset Supervisor

This block drives the active-low reset of a processor from three causes: loss of supply (seen as a digital power-good bit), a pushbutton wired onto the reset line itself, and a software watchdog that must be strobed. It can only ever pull the shared reset line low. Its output is an enable for a low-side driver, and an external pull-up returns the line high. The level of that line is read back through a synchronizer, so a button that shorts the line to ground is seen as a falling edge while the block is idle.

All timing counts a one-millisecond tick enable. A reset pulse lasts `HOLD_MS` ticks. The watchdog period is chosen by a two-bit select register held inside the block. If a button is still held when a pulse ends, the block lets go of the line and waits for the button to be released. It then issues a second full pulse, so the processor leaves reset only after the button is up. Power failure overrides everything else.

Top module: `reset_guard`

## Requirements
- R1: While `pwr_good` is low, `line_drive_lo` is high from the next clock edge on, whatever the state of the other inputs.
- R2: When `pwr_good` returns high, `line_drive_lo` stays high for exactly `HOLD_MS` further ticks and then falls.
- R3: While the block is idle (not pulsing, not waiting for release), a falling edge on `line_in` is seen after the two-flop synchronizer. It starts a pulse of exactly `HOLD_MS` ticks, with `line_drive_lo` high from the third clock edge after the line fell.
- R4: When any pulse ends, the block releases the line and waits `SYNC_STAGES`+1 cycles before it samples the synchronized line. If the line is still low, the block drives nothing until a rising edge is seen. It then issues one more pulse of exactly `HOLD_MS` ticks.
- R5: The period select decodes as follows: 2'b00 disables the watchdog, 2'b01 selects `BASE_MS` ticks, 2'b10 selects 2×`BASE_MS` and 2'b11 selects 4×`BASE_MS`. The idle time from the end of a pulse to a watchdog pulse is `SYNC_STAGES`+1 cycles plus the period.
- R6: The select register reads 2'b11 after reset. A cycle with `sel_we` high loads `sel_wdata`, which appears on `sel_q` after that edge.
- R7: The watchdog counts only while the block is idle. It starts from the full period every time idle is entered, and its count is zero while a pulse or a release wait is in progress.
- R8: A high-to-low transition of `strobe_n` (after synchronization) restarts the watchdog period. Strobing more often than the period prevents any pulse, and after the last strobe falls a pulse begins `BASE_MS`+3 edges later when the period is `BASE_MS`.
- R9: When the watchdog expires, `line_drive_lo` rises on the next edge and stays high for exactly `HOLD_MS` ticks.
- R10: A power failure during a pushbutton or watchdog pulse aborts that pulse. On recovery the full `HOLD_MS` hold starts again from zero.
- R11: Every timed interval advances only in cycles where `tick_ms` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (acts as initial power-up) |
| tick_ms | input | 1 | One-cycle enable marking each millisecond |
| pwr_good | input | 1 | High while supply is within limits |
| line_in | input | 1 | Sampled level of the shared reset line |
| strobe_n | input | 1 | Watchdog strobe, active on its falling edge |
| sel_we | input | 1 | Write enable for the period select register |
| sel_wdata | input | 2 | New period select code |
| line_drive_lo | output | 1 | Enable for the low-side driver of the reset line |
| sel_q | output | 2 | Current period select code |

## Verification
The assertions check, on every cycle, the relations that hold locally between power-good and the driver, between watchdog expiry and the next pulse, and between the idle state and the watchdog counter, including the zero count outside idle and the clear on a strobe. Durations are beyond what these local checks can see. So are the settle-and-release sequence of a held button, the second pulse after release, the restart of the hold after a power dip in mid-pulse, and the stretching of intervals when ticks are sparse. A behavioural model in the bench, driven by a pin model of the open-drain line, checks these end to end by comparing the driver and the select readback on every clock and by measuring pulse and idle lengths.

// File: rtl/rg_pkg.sv
// Shared types for the reset supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package rg_pkg;

    // Supervisor sequencing states.
    typedef enum logic [2:0] {
        ST_PWR    = 3'd0,  // supply bad, line held low
        ST_HOLD   = 3'd1,  // timed reset pulse
        ST_SETTLE = 3'd2,  // released, letting readback catch up
        ST_WAIT   = 3'd3,  // button held, waiting for release
        ST_RUN    = 3'd4   // idle, watching button and watchdog
    } rg_state_t;

endpackage

// File: rtl/rg_sync.sv
// Multi-bit synchronizer with one extra history stage for edge detection.
// Assumes: each bit is an independent slow level; no bus coherency is needed.
module rg_sync #(
    parameter int              W      = 2,
    parameter int              STAGES = 2,
    parameter logic [W-1:0]    INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] prev
);
    logic [STAGES:0][W-1:0] chain;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {(STAGES+1){INIT}};
        else        chain <= {chain[STAGES-1:0], d};
    end

    assign q    = chain[STAGES-1];
    assign prev = chain[STAGES];
endmodule

// File: rtl/rg_wdog.sv
// Watchdog counter: counts ticks while the supervisor is idle and flags
// expiry when the selected period elapses without a strobe.
// Assumes: run drops for at least one cycle after each expiry.
module rg_wdog #(
    parameter int BASE_MS = 250,
    parameter int CW      = $clog2(4*BASE_MS+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          kick,
    input  logic [1:0]    sel,
    output logic          expire,
    output logic [CW-1:0] cnt
);
    localparam logic [CW:0] P1 = (CW+1)'(BASE_MS);
    localparam logic [CW:0] P2 = (CW+1)'(2*BASE_MS);
    localparam logic [CW:0] P4 = (CW+1)'(4*BASE_MS);

    logic [CW:0] limit;
    logic        enabled;

    // Decode the period select code into a tick count.
    always_comb begin
        unique case (sel)
            2'b01:   limit = P1;
            2'b10:   limit = P2;
            2'b11:   limit = P4;
            default: limit = '0;
        endcase
    end

    assign enabled = (sel != 2'b00);
    assign expire  = run && tick && !kick && enabled &&
                     (({1'b0, cnt} + 1'b1) >= limit);

    // Count elapsed ticks; clear outside idle or on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (!run || kick)               cnt <= '0;
        else if (tick && enabled && !expire) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rg_ctrl.sv
// Sequencer: power-fail hold, timed pulses, release wait and idle watch.
// Assumes: line_lvl/rise/fall are already synchronized; pwr_good is
// synchronous to clk.
module rg_ctrl
    import rg_pkg::*;
#(
    parameter int HOLD_MS    = 250,
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_good,
    input  logic line_lvl,
    input  logic line_rise,
    input  logic line_fall,
    input  logic wd_expire,
    output logic run,
    output logic drive_lo
);
    localparam int              HCW       = $clog2(HOLD_MS+1);
    localparam int              SCW       = $clog2(SETTLE_CYC+1);
    localparam logic [HCW-1:0]  HOLD_LAST = HCW'(HOLD_MS-1);
    localparam logic [SCW-1:0]  SET_LAST  = SCW'(SETTLE_CYC-1);

    rg_state_t      state, nxt;
    logic [HCW-1:0] hcnt;
    logic [SCW-1:0] scnt;

    // Next-state selection; supply loss overrides every state.
    always_comb begin
        nxt = state;
        if (!pwr_good) begin
            nxt = ST_PWR;
        end else begin
            unique case (state)
                ST_PWR:    nxt = ST_HOLD;
                ST_HOLD:   if (tick && hcnt == HOLD_LAST) nxt = ST_SETTLE;
                ST_SETTLE: if (scnt == SET_LAST) nxt = line_lvl ? ST_RUN : ST_WAIT;
                ST_WAIT:   if (line_rise) nxt = ST_HOLD;
                ST_RUN:    if (line_fall || wd_expire) nxt = ST_HOLD;
                default:   nxt = ST_PWR;
            endcase
        end
    end

    // State register; reset behaves like initial power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PWR;
        else        state <= nxt;
    end

    // Pulse length counter in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_HOLD) hcnt <= '0;
        else if (tick)                  hcnt <= hcnt + 1'b1;
    end

    // Settle counter in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SETTLE) scnt <= '0;
        else                              scnt <= scnt + 1'b1;
    end

    assign run      = (state == ST_RUN);
    assign drive_lo = (state == ST_PWR) || (state == ST_HOLD);
endmodule

// File: rtl/reset_guard.sv
// Reset supervisor top: synchronizes the line readback and strobe, holds
// the watchdog period select, and combines sequencer and watchdog.
// Assumes: line_drive_lo enables a pull-down only; an external pull-up
// restores the line, and tick_ms is a single-cycle pulse per millisecond.
module reset_guard #(
    parameter int HOLD_MS     = 250,
    parameter int BASE_MS     = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       pwr_good,
    input  logic       line_in,
    input  logic       strobe_n,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    output logic       line_drive_lo,
    output logic [1:0] sel_q
);
    localparam int WD_CW      = $clog2(4*BASE_MS+1);
    localparam int SETTLE_CYC = SYNC_STAGES + 1;

    logic [1:0]       syn_q, syn_prev;
    logic             line_rise, line_fall, kick;
    logic             run, wd_expire;
    logic [WD_CW-1:0] wd_cnt;

    rg_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({strobe_n, line_in}),
        .q    (syn_q),
        .prev (syn_prev)
    );

    assign line_fall = syn_prev[0] & ~syn_q[0];
    assign line_rise = ~syn_prev[0] & syn_q[0];
    assign kick      = syn_prev[1] & ~syn_q[1];

    // Period select register; powers up enabled at the longest period.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 2'b11;
        else if (sel_we) sel_q <= sel_wdata;
    end

    rg_wdog #(.BASE_MS(BASE_MS), .CW(WD_CW)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ms),
        .run   (run),
        .kick  (kick),
        .sel   (sel_q),
        .expire(wd_expire),
        .cnt   (wd_cnt)
    );

    rg_ctrl #(.HOLD_MS(HOLD_MS), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .pwr_good (pwr_good),
        .line_lvl (syn_q[0]),
        .line_rise(line_rise),
        .line_fall(line_fall),
        .wd_expire(wd_expire),
        .run      (run),
        .drive_lo (line_drive_lo)
    );
endmodule

// File: rtl/rg_check.sv
// Property checker for reset_guard, attached with bind.
// Assumes: connected to the top's ports and its internal watchdog nets.
module rg_check #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          line_drive_lo,
    input logic [1:0]    sel_q,
    input logic          run,
    input logic          kick,
    input logic          wd_expire,
    input logic [CW-1:0] wd_cnt
);
    AST_PF_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> line_drive_lo);  // R1

    AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |=> line_drive_lo);  // R2

    AST_SEL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sel_q == 2'b11);  // R6

    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q == 2'b00 |-> !wd_expire);  // R5

    AST_IDLE_ONLY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> wd_cnt == '0);  // R7

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kick) |=> wd_cnt == '0);  // R8

    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> line_drive_lo);  // R9
endmodule

bind reset_guard rg_check #(.CW(WD_CW)) u_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .line_drive_lo(line_drive_lo),
    .sel_q        (sel_q),
    .run          (run),
    .kick         (kick),
    .wd_expire    (wd_expire),
    .wd_cnt       (wd_cnt)
);

// File: tb/reset_guard_test.sv
module reset_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 250;
    localparam int BASE       = 250;
    localparam int SETTLE     = 3;

    localparam int M_PF = 0, M_HOLD = 1, M_SETTLE = 2, M_WAIT = 3, M_RUN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       pg = 1'b0;
    logic       button = 1'b0;
    logic       strobe_n = 1'b1;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       line_in;
    logic       line_drive_lo;
    logic [1:0] sel_q;

    int checks = 0;
    int fails = 0;
    int tick_div = 1;
    int cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    // pin model: open drain with pull-up; button shorts the line
    assign line_in = !(line_drive_lo || button);

    reset_guard uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick), .pwr_good(pg),
        .line_in(line_in), .strobe_n(strobe_n), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .line_drive_lo(line_drive_lo), .sel_q(sel_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick pattern
    always @(negedge clk) begin
        cyc++;
        tick = (tick_div <= 1) || (cyc % tick_div == 0);
    end

    // ---------------- behavioural reference model ----------------
    int  m_mode = M_PF;
    bit  m_drive = 1;
    int  m_sel = 3;
    int  m_rem = 0, m_st = 0, m_wd = 0;
    bit  m_l1 = 1, m_l2 = 1, m_lp = 1, m_s1 = 1, m_s2 = 1, m_sp = 1;
    bit  m_line, m_lfall, m_lrise, m_sfall, m_tmo;
    int  m_per;

    always @(posedge clk) begin
        m_line = !(m_drive || button);
        if (!rst_n) begin
            m_mode = M_PF; m_sel = 3; m_rem = 0; m_st = 0; m_wd = 0;
            m_l1 = 1; m_l2 = 1; m_lp = 1; m_s1 = 1; m_s2 = 1; m_sp = 1;
        end else begin
            m_lfall = m_lp && !m_l2;
            m_lrise = !m_lp && m_l2;
            m_sfall = m_sp && !m_s2;
            m_tmo = 0;
            m_per = (m_sel == 1) ? BASE : (m_sel == 2) ? 2*BASE : 4*BASE;
            if (m_mode == M_RUN) begin
                if (m_sfall) m_wd = 0;
                else if (tick && m_sel != 0) begin
                    if (m_wd + 1 >= m_per) m_tmo = 1;
                    else m_wd++;
                end
            end
            if (!pg) m_mode = M_PF;
            else case (m_mode)
                M_PF: begin m_mode = M_HOLD; m_rem = HOLD; end
                M_HOLD: if (tick) begin
                    m_rem--;
                    if (m_rem == 0) begin m_mode = M_SETTLE; m_st = SETTLE; end
                end
                M_SETTLE: begin
                    m_st--;
                    if (m_st == 0) begin
                        if (m_l2) begin m_mode = M_RUN; m_wd = 0; end
                        else m_mode = M_WAIT;
                    end
                end
                M_WAIT: if (m_lrise) begin m_mode = M_HOLD; m_rem = HOLD; end
                default: if (m_lfall || m_tmo) begin m_mode = M_HOLD; m_rem = HOLD; end
            endcase
            if (sel_we) m_sel = sel_wdata;
            m_lp = m_l2; m_l2 = m_l1; m_l1 = m_line;
            m_sp = m_s2; m_s2 = m_s1; m_s1 = strobe_n;
        end
        m_drive = (m_mode == M_PF) || (m_mode == M_HOLD);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (line_drive_lo !== m_drive || sel_q !== 2'(m_sel)) begin
                fails++;
                $display("FAIL %s cycle %0d: drive=%0b sel=%0d expected drive=%0b sel=%0d",
                         cur_req, cyc, line_drive_lo, sel_q, m_drive, m_sel);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_sel(input logic [1:0] v);
        @(negedge clk); sel_we = 1'b1; sel_wdata = v;
        @(negedge clk); sel_we = 1'b0;
    endtask

    task automatic tap();
        @(negedge clk); button = 1'b1;
        @(negedge clk); button = 1'b0;
    endtask

    task automatic pulse(output int hi);
        hi = 0;
        while (!line_drive_lo) @(negedge clk);
        while (line_drive_lo) begin hi++; @(negedge clk); end
    endtask

    task automatic idle(input int limit, output int lo);
        lo = 0;
        while (!line_drive_lo && lo < limit) begin lo++; @(negedge clk); end
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    // ---------------- scenarios ----------------
    initial begin
        int hi, lo, hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 reset drive", line_drive_lo, 1);
        chk("R6 reset sel", sel_q, 3);
        repeat (5) @(negedge clk);
        chk("R1 pg low", line_drive_lo, 1);

        // R2 recovery hold
        cur_req = "R2";
        pg = 1'b1; @(negedge clk);
        pulse(hi);
        chk("R2 hold length", hi, HOLD);

        // R5 disabled, R6 write
        cur_req = "R5";
        wr_sel(2'b00);
        chk("R6 write readback", sel_q, 0);
        idle(1200, lo);
        chk("R5 disabled no pulse", lo, 1200);

        // R5/R9/R7 timed periods
        wr_sel(2'b01);
        tap();
        pulse(hi);
        chk("R3 tap pulse", hi, HOLD);
        idle(3000, lo);
        chk("R5 period 01", lo, SETTLE + BASE);
        cur_req = "R9";
        pulse(hi);
        chk("R9 timeout pulse", hi, HOLD);
        idle(3000, lo);
        chk("R7 full period again", lo, SETTLE + BASE);
        cur_req = "R5";
        wr_sel(2'b10);
        pulse(hi);
        idle(3000, lo);
        chk("R5 period 10", lo, SETTLE + 2*BASE);
        wr_sel(2'b11);
        pulse(hi);
        idle(3000, lo);
        chk("R5 period 11", lo, SETTLE + 4*BASE);
        wr_sel(2'b00);
        pulse(hi);
        idle(300, lo);
        chk("R5 off after pulse", lo, 300);

        // R3 pushbutton tap
        cur_req = "R3";
        tap();
        pulse(hi);
        chk("R3 pushbutton pulse", hi, HOLD);
        idle(50, lo);

        // R4 held button, second pulse on release
        cur_req = "R4";
        @(negedge clk); button = 1'b1;
        pulse(hi);
        chk("R4 first pulse", hi, HOLD);
        idle(100, lo);
        chk("R4 waits while held", lo, 100);
        button = 1'b0;
        @(negedge clk);
        pulse(hi);
        chk("R4 second pulse", hi, HOLD);
        idle(50, lo);
        chk("R4 idle after release", lo, 50);

        // R8 strobes
        cur_req = "R8";
        wr_sel(2'b01);
        tap();
        pulse(hi);
        idle(10, lo);
        hits = 0;
        for (int k = 0; k < 5; k++) begin
            for (int j = 0; j < 150; j++) begin
                @(negedge clk);
                if (line_drive_lo) hits++;
            end
            strobe_n = 1'b0;
            @(negedge clk);
            strobe_n = 1'b1;
            if (k < 4) begin
                @(negedge clk);
                if (line_drive_lo) hits++;
            end
        end
        chk("R8 strobes hold off", hits, 0);
        lo = 0;
        while (!line_drive_lo) begin lo++; @(negedge clk); end
        chk("R8 gap after last strobe", lo, BASE + 2);
        wr_sel(2'b00);
        pulse(hi);
        idle(20, lo);

        // R10 power fail inside a pulse
        cur_req = "R10";
        tap();
        while (!line_drive_lo) @(negedge clk);
        repeat (100) @(negedge clk);
        pg = 1'b0;
        hits = 0;
        repeat (10) begin @(negedge clk); if (!line_drive_lo) hits++; end
        chk("R1 drive during dip", hits, 0);
        pg = 1'b1;
        @(negedge clk);
        pulse(hi);
        chk("R10 hold restarted", hi, HOLD);
        idle(20, lo);

        // R11 sparse ticks
        cur_req = "R11";
        tick_div = 4;
        tap();
        pulse(hi);
        chk("R11 pulse stretched", (hi >= 4*HOLD - 3 && hi <= 4*HOLD) ? 1 : 0, 1);
        tick_div = 1;
        idle(20, lo);

        summary();
    end
endmodule